// File: doc/BRIEF.md
# Flash Control and Status Register

This block is a single 32-bit memory-mapped register that sits beside an embedded flash array. It samples the flash ready line, which is high while the flash is idle and low while an erase or program sequence runs. Every low-to-high change of that line is latched in a sticky "operation done" flag. The flag clears itself when the CPU reads the register, so software can poll for completion without missing an event.

The same word holds three writable controls. One selects 16-bit rather than 32-bit flash accesses. One is a test control that forces the ready output high. One enables the boot ROM; while it is off, flash is mapped into the boot ROM's address window. The register is reached over a simple slave port with an address, read and write strobes, write data and byte enables. Read data appears on the cycle after the read strobe.

Top module: `flash_csr`

## Requirements
- R1: After reset, `wide16Sel` and `readyForce` are 0, `bootRomEn` is 1, and the done flag is 0.
- R2: A read strobe at address `REG_ADDR` (default 0x7000) places the register on `busRdata` in the next cycle, with this layout: bit 29 boot-ROM enable, bit 28 done flag, bit 27 ready level, bit 26 ready force, bit 25 16-bit mode. In the cycle after a read at any other address, or after no read at all, `busRdata` is 0.
- R3: Bit 27 reads the level of `flashReady` after it has passed through a synchronizer of `SYNC_STAGES` flops.
- R4: A rising edge of the synchronized ready level sets the done flag. The flag then stays set until it is cleared.
- R5: A read at `REG_ADDR` returns the done flag as it was before the read and clears the flag afterwards.
- R6: If a rising edge of the ready level and a clearing read fall in the same cycle, the read returns the old flag value and the flag ends up set.
- R7: A write at `REG_ADDR` with byte enable 3 asserted loads bits 29, 26 and 25 from the write data. `bootRomEn`, `readyForce` and `wide16Sel` follow these bits.
- R8: Writes leave bits 28 and 27 unchanged. Bits 31:30 and 24:0 always read 0.
- R9: A write with byte enable 3 low, or a write at any other address, changes no control bit.
- R10: A falling edge of the ready line, or a ready level that stays high, never sets the done flag.
- R11: A read at any other address leaves the done flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte enables; bit n covers data bits 8n+7:8n |
| busRdata | output | 32 | Registered read data, valid the cycle after the read strobe |
| flashReady | input | 1 | Flash ready line, asynchronous; high means idle |
| wide16Sel | output | 1 | 1 selects 16-bit flash accesses, 0 selects 32-bit |
| readyForce | output | 1 | Test control that forces the ready output high |
| bootRomEn | output | 1 | 1 enables the boot ROM; 0 maps flash into its window |

## Verification
The assertions assume that `flashReady` holds each new level for longer than the synchronizer delay. They also assume that the bus raises `busRd` and `busWr` for a single cycle per access and never raises both in the same cycle. The bench drives the bus only at falling clock edges and uses one-cycle strobes. It holds every ready level for at least four cycles. The one exception is the test that deliberately lines up a read strobe with the cycle in which the synchronized edge appears.

// File: rtl/flash_csr_pkg.sv
package flash_csr_pkg;

  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;

  // Bit positions that software decodes
  localparam int BOOT_BIT  = 29;
  localparam int DONE_BIT  = 28;
  localparam int RDY_BIT   = 27;
  localparam int FORCE_BIT = 26;
  localparam int WIDE_BIT  = 25;

  localparam int CTL_LANE  = BOOT_BIT / 8;

  typedef struct packed {
    logic             rdHit;
    logic [LANES-1:0] wrLane;
  } csrStrobe_t;

endpackage

// File: rtl/flash_csr_ctrl.sv
module flash_csr_ctrl
  import flash_csr_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h7000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [LANES-1:0]  busBe,
  output csrStrobe_t        stb
);

  logic addrHit;

  always_comb begin
    addrHit    = (busAddr == REG_ADDR);
    stb.rdHit  = busRd & addrHit;
  end

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      assign stb.wrLane[gl] = busWr & addrHit & busBe[gl];
    end
  endgenerate

endmodule

// File: rtl/flash_csr_dp.sv
module flash_csr_dp
  import flash_csr_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic BOOT_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              flashReady,
  output logic [DATA_W-1:0] rdDataQ,
  output logic              wide16Sel,
  output logic              readyForce,
  output logic              bootRomEn
);

  // Ready synchronizer; idle level (1) on reset so no event is seen at start-up
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   readyLvl;
  logic                   prevQ;
  logic                   riseEv;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= flashReady;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], flashReady};
    end
  endgenerate

  assign readyLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= readyLvl;

  assign riseEv = readyLvl & ~prevQ;

  // Sticky done flag: a set wins over a clearing read
  logic doneQ;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          doneQ <= 1'b0;
    else if (riseEv)    doneQ <= 1'b1;
    else if (stb.rdHit) doneQ <= 1'b0;

  // Writable controls, all in one byte lane
  logic bootQ, forceQ, wideQ;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bootQ  <= BOOT_RST;
      forceQ <= 1'b0;
      wideQ  <= 1'b0;
    end else if (stb.wrLane[CTL_LANE]) begin
      bootQ  <= busWdata[BOOT_BIT];
      forceQ <= busWdata[FORCE_BIT];
      wideQ  <= busWdata[WIDE_BIT];
    end

  assign bootRomEn  = bootQ;
  assign readyForce = forceQ;
  assign wide16Sel  = wideQ;

  logic [DATA_W-1:0] regVal;
  always_comb begin
    regVal            = '0;
    regVal[BOOT_BIT]  = bootQ;
    regVal[DONE_BIT]  = doneQ;
    regVal[RDY_BIT]   = readyLvl;
    regVal[FORCE_BIT] = forceQ;
    regVal[WIDE_BIT]  = wideQ;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          rdDataQ <= '0;
    else if (stb.rdHit) rdDataQ <= regVal;
    else                rdDataQ <= '0;

  logic wdataUnused;
  assign wdataUnused = ^{busWdata, stb.wrLane};

  // R4
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseEv |=> doneQ);

  // R5
  done_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdHit && !riseEv) |=> !doneQ);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!riseEv && !stb.rdHit) |=> $stable(doneQ));

  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrLane[CTL_LANE] |=> $stable({bootRomEn, readyForce, wide16Sel}));

  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdHit |=> (rdDataQ == '0));

endmodule

// File: rtl/flash_csr.sv
module flash_csr
  import flash_csr_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 16'h7000,
  parameter int                SYNC_STAGES = 2,
  parameter logic              BOOT_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  input  logic [3:0]        busBe,
  output logic [31:0]       busRdata,
  input  logic              flashReady,
  output logic              wide16Sel,
  output logic              readyForce,
  output logic              bootRomEn
);

  csrStrobe_t stb;

  flash_csr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busBe   (busBe),
    .stb     (stb)
  );

  flash_csr_dp #(.SYNC_STAGES(SYNC_STAGES), .BOOT_RST(BOOT_RST)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWdata   (busWdata),
    .flashReady (flashReady),
    .rdDataQ    (busRdata),
    .wide16Sel  (wide16Sel),
    .readyForce (readyForce),
    .bootRomEn  (bootRomEn)
  );

endmodule

// File: tb/test_flash_csr.sv
module test_flash_csr;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] REG_A      = 16'h7000;
  localparam logic [15:0] OTHER_A    = 16'h7004;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdata;
  logic        flashReady = 1'b1;
  logic        wide16Sel, readyForce, bootRomEn;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_csr i_flash_csr (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busBe(busBe), .busRdata(busRdata),
    .flashReady(flashReady), .wide16Sel(wide16Sel),
    .readyForce(readyForce), .bootRomEn(bootRomEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busAddr = a; busWdata = d; busBe = be; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busBe = '0;
  endtask

  task automatic setReady(input logic v);
    @(negedge clk);
    flashReady = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 wide16Sel", {31'd0, wide16Sel}, 32'd0);
    check("R1 readyForce", {31'd0, readyForce}, 32'd0);
    check("R1 bootRomEn", {31'd0, bootRomEn}, 32'd1);
    doRead(REG_A, d);
    check("R1 R2 reset readback", d, 32'h2800_0000);
    doRead(OTHER_A, d);
    check("R2 other address reads 0", d, 32'h0);
    @(negedge clk);
    check("R2 idle rdata 0", busRdata, 32'h0);
  endtask

  task automatic t_riseAndClear;
    logic [31:0] d;
    setReady(1'b0);
    doRead(REG_A, d);
    check("R3 R10 ready low, no flag", d, 32'h2000_0000);
    setReady(1'b1);
    doRead(REG_A, d);
    check("R4 flag set after rise", d, 32'h3800_0000);
    doRead(REG_A, d);
    check("R5 flag cleared by read", d, 32'h2800_0000);
    repeat (10) @(negedge clk);
    doRead(REG_A, d);
    check("R10 steady high does not set", d, 32'h2800_0000);
  endtask

  task automatic t_coincident;
    logic [31:0] d;
    @(negedge clk);
    flashReady = 1'b0;
    repeat (4) @(negedge clk);
    flashReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = REG_A; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
    check("R6 coincident read returns old flag", d & 32'h1000_0000, 32'h0);
    doRead(REG_A, d);
    check("R6 flag survives coincident read", d, 32'h3800_0000);
    doRead(REG_A, d);
    check("R5 cleared after second read", d, 32'h2800_0000);
  endtask

  task automatic t_otherRead;
    logic [31:0] d;
    setReady(1'b0);
    setReady(1'b1);
    doRead(OTHER_A, d);
    check("R11 other read data 0", d, 32'h0);
    doRead(REG_A, d);
    check("R11 flag kept over other read", d, 32'h3800_0000);
  endtask

  task automatic t_write;
    logic [31:0] d;
    doWrite(REG_A, 32'h0600_0000, 4'b1000);
    check("R7 outputs after write", {29'd0, bootRomEn, readyForce, wide16Sel}, 32'd3);
    doRead(REG_A, d);
    check("R7 readback", d, 32'h0E00_0000);
    doWrite(REG_A, 32'hFFFF_FFFF, 4'b1111);
    doRead(REG_A, d);
    check("R8 read-only and unused bits", d, 32'h2E00_0000);
    doWrite(REG_A, 32'h0000_0000, 4'b0111);
    doRead(REG_A, d);
    check("R9 lane 3 disabled", d, 32'h2E00_0000);
    doWrite(OTHER_A, 32'h0000_0000, 4'b1111);
    doRead(REG_A, d);
    check("R9 other address write", d, 32'h2E00_0000);
    check("R9 outputs held", {29'd0, bootRomEn, readyForce, wide16Sel}, 32'd7);
    doWrite(REG_A, 32'h2000_0000, 4'b1000);
    check("R7 outputs restored", {29'd0, bootRomEn, readyForce, wide16Sel}, 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_riseAndClear();
    t_coincident();
    t_otherRead();
    t_write();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule